// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache with an owner tag on every entry. A lookup presents a virtual page number, the current process tag, the privilege level and the access type. All entries are compared against it in parallel. One cycle later the block reports one of three outcomes. A hit returns the frame number, the cacheable attribute and the modify state. A miss means no valid entry matches. A protection fault means an entry matches but its rights forbid the access.

An external page walker fills entries through a refill port. A refill goes to the entry that already holds the same page and tag if there is one. Otherwise it goes to a free entry, and only when no entry is free does it evict the least recently used one. Three invalidate commands cover a changed page table entry, a retired process and a full context reset.

Top module: `tagged_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, and every lookup reports a miss.
- R2: Every lookup request yields `rsp_valid` exactly one cycle later, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. Without a request, `rsp_valid` is 0.
- R3: A hit needs a valid entry whose page number and process tag both equal the lookup's. The response then carries that entry's frame number and cacheable bit. A tag mismatch reports a miss.
- R4: Each entry has separate kernel and user rights, each 2 bits: 00 = no access, 01 = read only, 1x = read and write. The rights for the lookup's privilege level are used. A matching entry whose rights forbid the access reports `rsp_fault`, with `rsp_pfn` = 0.
- R5: A permitted write hit sets the entry's modify bit. `rsp_dirty` on a hit shows the modify bit as it stands after that access. A refill clears the bit, and a faulting write leaves it unchanged.
- R6: A refill whose page and tag equal those of a valid entry rewrites that entry in place, so no two valid entries ever share a page and tag.
- R7: A refill that matches no entry uses the lowest-numbered free entry while any entry is free.
- R8: When all entries are valid, a refill evicts the entry whose last hit or refill is the oldest.
- R9: Page invalidate (`inv_kind` = 00) clears only the entry with the given page and tag.
- R10: Process invalidate (`inv_kind` = 01) clears every entry carrying the given tag and no other entry.
- R11: Full invalidate (`inv_kind` = 1x) clears every entry in one cycle.
- R12: A lookup and a refill in the same cycle: the lookup sees the contents held before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Current process tag |
| lk_kernel | input | 1 | 1 = kernel access, 0 = user access |
| lk_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry, access forbidden |
| rsp_pfn | output | PFN_W | Frame number on hit, else 0 |
| rsp_cacheable | output | 1 | Cacheable bit of the hit entry |
| rsp_dirty | output | 1 | Modify bit of the hit entry after the access |
| fill_en | input | 1 | Refill write |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pid | input | PID_W | Refill process tag |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_kperm | input | 2 | Kernel rights for the refill |
| fill_uperm | input | 2 | User rights for the refill |
| fill_cacheable | input | 1 | Cacheable bit for the refill |
| inv_en | input | 1 | Invalidate command |
| inv_kind | input | 2 | 00 page, 01 process, 1x all |
| inv_vpn | input | VPN_W | Page number for page invalidate |
| inv_pid | input | PID_W | Tag for page or process invalidate |

## Verification
Lookups run against entries that differ in only one field: the same page under another tag, the same tag on another page, and each pair of privilege level and access type. This separates tag matching, page matching and the rights decode. Refill sequences tell the victim rules apart. A full buffer with one entry recently touched exposes an LRU bug. A full buffer with one hole exposes a victim choice that ignores free entries. Repeated refills of one page followed by eight distinct pages reveal a duplicate entry, because the duplicate would push out a live page. A lookup issued together with a refill of the same page, and writes followed by reads, check the timing of the response and of the modify bit.

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_kernel,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_cacheable,
  output logic             rsp_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_kperm,
  input  logic [1:0]       fill_uperm,
  input  logic             fill_cacheable,
  input  logic             inv_en,
  input  logic [1:0]       inv_kind,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [PID_W-1:0] inv_pid
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] e_val, e_mod, e_cch;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PID_W-1:0]   e_pid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [1:0]         e_kp  [ENTRIES];
  logic [1:0]         e_up  [ENTRIES];
  logic [IW-1:0]      e_age [ENTRIES];

  logic [ENTRIES-1:0] lk_match, f_match, kill;
  logic [IW-1:0]      hit_idx, f_idx, free_idx, lru_idx, victim, touch_idx;
  logic               any_free;

  always_comb begin
    hit_idx = '0; f_idx = '0; free_idx = '0; lru_idx = '0; any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      lk_match[i] = e_val[i] && e_vpn[i] == lk_vpn && e_pid[i] == lk_pid;
      f_match[i]  = e_val[i] && e_vpn[i] == fill_vpn && e_pid[i] == fill_pid;
      kill[i]     = inv_en && (inv_kind[1] || (e_pid[i] == inv_pid &&
                    (inv_kind[0] || e_vpn[i] == inv_vpn)));
      if (lk_match[i]) hit_idx = IW'(i);
      if (f_match[i]) f_idx = IW'(i);
      if (!e_val[i]) begin free_idx = IW'(i); any_free = 1'b1; end
      if (e_age[i] == OLDEST) lru_idx = IW'(i);
    end
  end

  wire       lk_any  = |lk_match;
  wire [1:0] perm    = lk_kernel ? e_kp[hit_idx] : e_up[hit_idx];
  wire       allowed = lk_write ? perm[1] : |perm;
  wire       lk_ok   = lk_req && lk_any && allowed;

  assign victim    = (|f_match) ? f_idx : (any_free ? free_idx : lru_idx);
  assign touch_idx = fill_en ? victim : hit_idx;
  wire   touch_en  = fill_en || lk_ok;
  wire [IW-1:0] touch_age = e_age[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_val <= '0;
      e_mod <= '0;
      for (int i = 0; i < ENTRIES; i++) e_age[i] <= IW'(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && victim == IW'(i)) begin
          e_val[i] <= 1'b1;
          e_mod[i] <= 1'b0;
          e_cch[i] <= fill_cacheable;
          e_vpn[i] <= fill_vpn;
          e_pid[i] <= fill_pid;
          e_pfn[i] <= fill_pfn;
          e_kp[i]  <= fill_kperm;
          e_up[i]  <= fill_uperm;
        end else begin
          if (kill[i]) e_val[i] <= 1'b0;
          if (lk_ok && lk_write && hit_idx == IW'(i)) e_mod[i] <= 1'b1;
        end
        if (touch_en) begin
          if (touch_idx == IW'(i)) e_age[i] <= '0;
          else if (e_age[i] < touch_age) e_age[i] <= e_age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_fault <= 1'b0;
      rsp_pfn <= '0; rsp_cacheable <= 1'b0; rsp_dirty <= 1'b0;
    end else begin
      rsp_valid     <= lk_req;
      rsp_hit       <= lk_ok;
      rsp_miss      <= lk_req && !lk_any;
      rsp_fault     <= lk_req && lk_any && !allowed;
      rsp_pfn       <= lk_ok ? e_pfn[hit_idx] : '0;
      rsp_cacheable <= lk_ok && e_cch[hit_idx];
      rsp_dirty     <= lk_ok && (e_mod[hit_idx] || lk_write);
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (e_val[i] && e_val[j] && e_vpn[i] == e_vpn[j] && e_pid[i] == e_pid[j])
          dup = 1'b1;
  end

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));
  p_fault_no_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_pfn == '0);
  p_no_duplicate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
  p_full_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind[1] && !fill_en) |=> e_val == '0);
endmodule

// File: tb/tagged_tlb_bench.sv
`timescale 1ns/1ps
module tagged_tlb_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, lk_kernel = 0, lk_write = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0;
  logic [7:0]  lk_pid = 0, fill_pid = 0, inv_pid = 0;
  logic [15:0] fill_pfn = 0, rsp_pfn;
  logic [1:0]  fill_kperm = 0, fill_uperm = 0, inv_kind = 0;
  logic fill_en = 0, fill_cacheable = 0, inv_en = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_cacheable, rsp_dirty;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tagged_tlb u_tagged_tlb (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outcome code: 1 hit, 2 miss, 4 fault
  task automatic look(input [19:0] v, input [7:0] p, input bit k, input bit w,
                      input int exp_out, input [15:0] exp_pfn, input string req);
    int got;
    @(negedge clk);
    lk_req = 1; lk_vpn = v; lk_pid = p; lk_kernel = k; lk_write = w;
    @(negedge clk);
    lk_req = 0;
    got = {rsp_fault, rsp_miss, rsp_hit};
    chk(rsp_valid && got == exp_out, req, got, exp_out);
    if (exp_out == 1) chk(rsp_pfn == exp_pfn, req, rsp_pfn, exp_pfn);
  endtask

  task automatic fill(input [19:0] v, input [7:0] p, input [15:0] f,
                      input [1:0] kp = 2'b11, input [1:0] up = 2'b11, input bit c = 0);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pid = p; fill_pfn = f;
    fill_kperm = kp; fill_uperm = up; fill_cacheable = c;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic inval(input [1:0] kind, input [19:0] v, input [7:0] p);
    @(negedge clk);
    inv_en = 1; inv_kind = kind; inv_vpn = v; inv_pid = p;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic t_reset;
    chk(!rsp_valid, "R1", rsp_valid, 0);
    look(20'h00000, 8'h00, 1, 0, 2, 0, "R1");
    look(20'h12345, 8'h07, 0, 0, 2, 0, "R1");
  endtask

  task automatic t_match;
    inval(2'b10, 0, 0);
    fill(20'h00100, 8'h01, 16'hA100, 2'b11, 2'b11, 1);
    look(20'h00100, 8'h01, 0, 0, 1, 16'hA100, "R3");
    chk(rsp_cacheable, "R3 cacheable", rsp_cacheable, 1);
    look(20'h00100, 8'h02, 0, 0, 2, 0, "R3 tag mismatch");
    look(20'h00101, 8'h01, 0, 0, 2, 0, "R3 page mismatch");
    @(negedge clk);
    chk(!rsp_valid, "R2 idle", rsp_valid, 0);
  endtask

  task automatic t_perm;
    inval(2'b10, 0, 0);
    fill(20'h00200, 8'h01, 16'hB200, 2'b11, 2'b01);
    fill(20'h00201, 8'h01, 16'hB201, 2'b01, 2'b00);
    look(20'h00200, 8'h01, 1, 1, 1, 16'hB200, "R4 kernel write");
    look(20'h00200, 8'h01, 0, 0, 1, 16'hB200, "R4 user read");
    look(20'h00200, 8'h01, 0, 1, 4, 0, "R4 user write");
    chk(rsp_pfn == 0, "R4 fault pfn", rsp_pfn, 0);
    look(20'h00201, 8'h01, 0, 0, 4, 0, "R4 user none");
    look(20'h00201, 8'h01, 1, 1, 4, 0, "R4 kernel read-only write");
    look(20'h00201, 8'h01, 1, 0, 1, 16'hB201, "R4 kernel read");
  endtask

  task automatic t_dirty;
    inval(2'b10, 0, 0);
    fill(20'h00300, 8'h03, 16'hC300, 2'b11, 2'b01);
    look(20'h00300, 8'h03, 0, 1, 4, 0, "R5 fault write");
    look(20'h00300, 8'h03, 0, 0, 1, 16'hC300, "R5");
    chk(!rsp_dirty, "R5 fault keeps clean", rsp_dirty, 0);
    look(20'h00300, 8'h03, 1, 1, 1, 16'hC300, "R5");
    chk(rsp_dirty, "R5 write sets", rsp_dirty, 1);
    look(20'h00300, 8'h03, 0, 0, 1, 16'hC300, "R5");
    chk(rsp_dirty, "R5 stays set", rsp_dirty, 1);
    fill(20'h00300, 8'h03, 16'hC301, 2'b11, 2'b01);
    look(20'h00300, 8'h03, 0, 0, 1, 16'hC301, "R5");
    chk(!rsp_dirty, "R5 refill clears", rsp_dirty, 0);
  endtask

  task automatic t_dup;
    inval(2'b10, 0, 0);
    fill(20'h00400, 8'h04, 16'h0001);
    fill(20'h00400, 8'h04, 16'h0002);
    look(20'h00400, 8'h04, 1, 0, 1, 16'h0002, "R6 in place");
    for (int i = 1; i < 8; i++) fill(20'h00400 + 20'(i), 8'h04, 16'(16'h0010 + i));
    look(20'h00400, 8'h04, 1, 0, 1, 16'h0002, "R6 no duplicate");
    for (int i = 1; i < 8; i++)
      look(20'h00400 + 20'(i), 8'h04, 1, 0, 1, 16'(16'h0010 + i), "R6 no duplicate");
  endtask

  task automatic t_lru;
    inval(2'b10, 0, 0);
    for (int i = 0; i < 8; i++) fill(20'h00500 + 20'(i), 8'h05, 16'(16'h0500 + i));
    look(20'h00500, 8'h05, 1, 0, 1, 16'h0500, "R8 touch");
    fill(20'h00508, 8'h05, 16'h0508);
    look(20'h00501, 8'h05, 1, 0, 2, 0, "R8 oldest evicted");
    look(20'h00500, 8'h05, 1, 0, 1, 16'h0500, "R8 touched kept");
    look(20'h00508, 8'h05, 1, 0, 1, 16'h0508, "R8 new entry");
    inval(2'b00, 20'h00505, 8'h05);
    look(20'h00505, 8'h05, 1, 0, 2, 0, "R9 page cleared");
    fill(20'h00600, 8'h05, 16'h0600);
    look(20'h00600, 8'h05, 1, 0, 1, 16'h0600, "R7");
    for (int i = 0; i < 9; i++)
      if (i != 1 && i != 5)
        look(20'h00500 + 20'(i), 8'h05, 1, 0, 1, 16'(16'h0500 + i), "R7 free entry used");
  endtask

  task automatic t_inval;
    inval(2'b10, 0, 0);
    fill(20'h00700, 8'h01, 16'h0700);
    fill(20'h00701, 8'h01, 16'h0701);
    fill(20'h00700, 8'h02, 16'h0702);
    inval(2'b00, 20'h00700, 8'h01);
    look(20'h00700, 8'h01, 1, 0, 2, 0, "R9");
    look(20'h00701, 8'h01, 1, 0, 1, 16'h0701, "R9 other page kept");
    look(20'h00700, 8'h02, 1, 0, 1, 16'h0702, "R9 other tag kept");
    fill(20'h00700, 8'h01, 16'h0700);
    inval(2'b01, 0, 8'h01);
    look(20'h00700, 8'h01, 1, 0, 2, 0, "R10");
    look(20'h00701, 8'h01, 1, 0, 2, 0, "R10");
    look(20'h00700, 8'h02, 1, 0, 1, 16'h0702, "R10 other tag kept");
    inval(2'b11, 0, 0);
    look(20'h00700, 8'h02, 1, 0, 2, 0, "R11");
  endtask

  task automatic t_same_cycle;
    inval(2'b10, 0, 0);
    @(negedge clk);
    lk_req = 1; lk_vpn = 20'h00800; lk_pid = 8'h08; lk_kernel = 1; lk_write = 0;
    fill_en = 1; fill_vpn = 20'h00800; fill_pid = 8'h08; fill_pfn = 16'h0800;
    fill_kperm = 2'b11; fill_uperm = 2'b11;
    @(negedge clk);
    lk_req = 0; fill_en = 0;
    chk(rsp_valid && rsp_miss, "R12 old contents", {rsp_valid, rsp_miss}, 2'b11);
    look(20'h00800, 8'h08, 1, 0, 1, 16'h0800, "R12 later hit");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: chk(!rsp_valid, "R1 in reset", rsp_valid, 0);
    rst_n = 1;
    t_reset;
    t_match;
    t_perm;
    t_dirty;
    t_dup;
    t_lru;
    t_inval;
    t_same_cycle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule